// File: doc/BRIEF.md
# Store-Miss Line Fill with Critical Word First

This block services a store that misses a write-back data cache. Once it accepts a store, it asks memory for the whole four-word line with one burst read. The burst starts at the word the store targets and wraps around the line. The beats land in a burst buffer. As the first beat arrives, the store's enabled bytes are merged into it. When all four beats have arrived and none reported a bus error, the block writes the complete line to the cache array in one cycle, tagged as modified-valid. It then signals that the store has finished.

If any beat reports an error, the block still drains the burst. It then discards the buffer, leaves the array untouched and raises a machine check. A store marked as going to a caching-inhibited region does not allocate a line: it is passed unchanged to the memory write port. Choosing the victim line and writing back the old contents are handled elsewhere.

Data interfaces are valid/ready. A transfer happens on a clock edge where both valid and ready are high. A valid output stays high with its payload stable until ready is seen. The store port is ready only while the block is idle, so a second store waits until the previous one has finished. The burst-beat port is ready only while the fill is in progress.

Top module: `store_miss_fill`

## Requirements
- R1: Each accepted cacheable store (st_inhibit=0) produces exactly one burst read request. Its address is the store address with the two byte-offset bits cleared.
- R2: Beats are taken in the order of word index c, c+1, c+2, c+3 modulo 4, where c is store address bits [3:2]. Word w of the written line appears at arr_data bits [32w+31:32w], and the write follows exactly four accepted beats.
- R3: In the critical word, byte b (bits [8b+7:8b]) comes from st_data when st_be[b]=1 and from the returned beat otherwise. The other three words are the returned beats unchanged.
- R4: After four error-free beats, arr_we is high for exactly one cycle, which is the cycle after the fourth beat. In that cycle arr_addr is the store address with bits [3:0] cleared, arr_state is 2'b11 (modified-valid), and st_done is high.
- R5: st_ready is high in idle and low from the cycle after a store is accepted until the cycle after the line write, the machine check, or the pass-through write.
- R6: If any beat of the fill carries rd_beat_err=1, including a beat the store does not touch, arr_we stays low and st_done stays low. mcheck pulses for one cycle, in the cycle after the fourth beat.
- R7: A store with st_inhibit=1 issues one write on the wr_* port carrying the unchanged address, data and byte enables. It issues no burst request and no array write. st_done is high in the cycle the write handshake completes.
- R8: rd_req_valid and wr_valid, once raised, stay high with stable payload until ready is seen. rd_beat_ready is high only during the fill, and cycles without rd_beat_valid are not counted as beats.
- R9: After reset the block is idle: st_ready=1 and rd_req_valid, rd_beat_ready, wr_valid, arr_we, mcheck and st_done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Block can accept a store |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_inhibit | input | 1 | Target region is caching-inhibited |
| st_done | output | 1 | Store completed (line written or pass-through accepted) |
| rd_req_valid | output | 1 | Burst read request valid |
| rd_req_ready | input | 1 | Bus accepts the request |
| rd_req_addr | output | ADDR_W | Word-aligned address of the critical word |
| rd_beat_valid | input | 1 | Burst beat valid |
| rd_beat_ready | output | 1 | Block accepts a beat |
| rd_beat_data | input | DATA_W | Beat data |
| rd_beat_err | input | 1 | Bus error on this beat |
| wr_valid | output | 1 | Pass-through write valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Pass-through write address |
| wr_data | output | DATA_W | Pass-through write data |
| wr_be | output | DATA_W/8 | Pass-through byte enables |
| arr_we | output | 1 | Cache array line write strobe |
| arr_addr | output | ADDR_W | Line-aligned address of the written line |
| arr_data | output | 4*DATA_W | Full line, word 0 in the low bits |
| arr_state | output | 2 | State written with the line |
| mcheck | output | 1 | Machine-check pulse on a failed fill |

## Verification
The bench puts the critical word at every position, including index 3, where the fill must wrap straight back to word 0. A design that places beats by arrival count instead of by index would scramble the line. Byte-enable patterns with gaps, and an all-zero mask, expose a merge that copies the whole word or that hits the wrong beat. Bus errors are injected both on a word the store does not touch and on the critical word itself. A design that writes the line anyway, stops after the faulty beat, or forgets to clear the error before the next store would be caught. Back-pressure on the request and write ports, together with idle cycles between beats, catches payloads that change while held and beats counted without a valid.

// File: rtl/smf_pkg.sv
package smf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_REQ,
    ST_FILL,
    ST_COMMIT,
    ST_FAULT
  } fsm_e;

  typedef enum logic [1:0] {
    LINE_INVALID = 2'b00,
    LINE_CLEAN   = 2'b01,
    LINE_DIRTY   = 2'b11
  } line_state_e;

endpackage

// File: rtl/smf_seq.sv
// Beat sequencer: tracks how many beats arrived and which word they belong to.
module smf_seq #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] crit_idx,
  input  logic             step,
  output logic [IDX_W-1:0] word_idx,
  output logic             first,
  output logic             last
);
  localparam logic [IDX_W-1:0] CNT_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] base_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= crit_idx;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // Index arithmetic wraps naturally in IDX_W bits.
  assign word_idx = base_q + cnt_q;
  assign first    = (cnt_q == '0);
  assign last     = (cnt_q == CNT_MAX);
endmodule

// File: rtl/smf_buf.sv
// Burst buffer: one register per line word, with a byte-level store merge.
module smf_buf #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(WORDS)-1:0]   idx,
  input  logic                       merge,
  input  logic [DATA_W-1:0]          beat_data,
  input  logic [DATA_W-1:0]          st_data,
  input  logic [DATA_W/8-1:0]        st_be,
  output logic [WORDS*DATA_W-1:0]    line
);
  localparam int BE_W  = DATA_W / 8;
  localparam int IDX_W = $clog2(WORDS);

  logic [DATA_W-1:0] merged;

  generate
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      always_comb begin
        if (merge && st_be[b]) merged[b*8 +: 8] = st_data[b*8 +: 8];
        else                   merged[b*8 +: 8] = beat_data[b*8 +: 8];
      end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           word_q <= '0;
        else if (we && idx == IDX_W'(w))     word_q <= merged;
      end
      assign line[w*DATA_W +: DATA_W] = word_q;
    end
  endgenerate
endmodule

// File: rtl/smf_ctrl.sv
// Control FSM for allocation fill and caching-inhibited pass-through.
module smf_ctrl
  import smf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic st_valid,
  input  logic st_inhibit,
  input  logic rd_req_ready,
  input  logic rd_beat_valid,
  input  logic rd_beat_err,
  input  logic wr_ready,
  input  logic last_beat,
  output logic st_fire,
  output logic beat_fire,
  output logic st_ready,
  output logic st_done,
  output logic rd_req_valid,
  output logic rd_beat_ready,
  output logic wr_valid,
  output logic arr_we,
  output logic mcheck
);
  fsm_e state_q, state_d;
  logic err_q;

  assign st_ready      = (state_q == ST_IDLE);
  assign rd_req_valid  = (state_q == ST_REQ);
  assign rd_beat_ready = (state_q == ST_FILL);
  assign wr_valid      = (state_q == ST_PASS);
  assign arr_we        = (state_q == ST_COMMIT);
  assign mcheck        = (state_q == ST_FAULT);
  assign st_fire       = st_valid && st_ready;
  assign beat_fire     = rd_beat_valid && rd_beat_ready;
  assign st_done       = arr_we || (wr_valid && wr_ready);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (st_fire) state_d = st_inhibit ? ST_PASS : ST_REQ;
      ST_PASS:   if (wr_ready) state_d = ST_IDLE;
      ST_REQ:    if (rd_req_ready) state_d = ST_FILL;
      ST_FILL:   if (beat_fire && last_beat)
                   state_d = (err_q || rd_beat_err) ? ST_FAULT : ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      ST_FAULT:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (st_fire)                       err_q <= 1'b0;
      else if (beat_fire && rd_beat_err) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/store_miss_fill.sv
module store_miss_fill
  import smf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         st_valid,
  output logic                         st_ready,
  input  logic [ADDR_W-1:0]            st_addr,
  input  logic [DATA_W-1:0]            st_data,
  input  logic [DATA_W/8-1:0]          st_be,
  input  logic                         st_inhibit,
  output logic                         st_done,
  output logic                         rd_req_valid,
  input  logic                         rd_req_ready,
  output logic [ADDR_W-1:0]            rd_req_addr,
  input  logic                         rd_beat_valid,
  output logic                         rd_beat_ready,
  input  logic [DATA_W-1:0]            rd_beat_data,
  input  logic                         rd_beat_err,
  output logic                         wr_valid,
  input  logic                         wr_ready,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W/8-1:0]          wr_be,
  output logic                         arr_we,
  output logic [ADDR_W-1:0]            arr_addr,
  output logic [LINE_WORDS*DATA_W-1:0] arr_data,
  output logic [1:0]                   arr_state,
  output logic                         mcheck
);
  localparam int BE_W     = DATA_W / 8;
  localparam int OFF_W    = $clog2(BE_W);
  localparam int IDX_W    = $clog2(LINE_WORDS);
  localparam int LINE_OFF = OFF_W + IDX_W;

  logic              st_fire, beat_fire;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;
  logic [IDX_W-1:0]  word_idx;
  logic              first_beat, last_beat;

  // Request capture; held stable for the whole transaction.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (st_fire) begin
      addr_q <= st_addr;
      data_q <= st_data;
      be_q   <= st_be;
    end
  end

  smf_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_valid      (st_valid),
    .st_inhibit    (st_inhibit),
    .rd_req_ready  (rd_req_ready),
    .rd_beat_valid (rd_beat_valid),
    .rd_beat_err   (rd_beat_err),
    .wr_ready      (wr_ready),
    .last_beat     (last_beat),
    .st_fire       (st_fire),
    .beat_fire     (beat_fire),
    .st_ready      (st_ready),
    .st_done       (st_done),
    .rd_req_valid  (rd_req_valid),
    .rd_beat_ready (rd_beat_ready),
    .wr_valid      (wr_valid),
    .arr_we        (arr_we),
    .mcheck        (mcheck)
  );

  smf_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (st_fire),
    .crit_idx (st_addr[OFF_W +: IDX_W]),
    .step     (beat_fire),
    .word_idx (word_idx),
    .first    (first_beat),
    .last     (last_beat)
  );

  smf_buf #(.DATA_W(DATA_W), .WORDS(LINE_WORDS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (beat_fire),
    .idx       (word_idx),
    .merge     (first_beat),
    .beat_data (rd_beat_data),
    .st_data   (data_q),
    .st_be     (be_q),
    .line      (arr_data)
  );

  assign rd_req_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign arr_addr    = {addr_q[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}};
  assign arr_state   = LINE_DIRTY;
  assign wr_addr     = addr_q;
  assign wr_data     = data_q;
  assign wr_be       = be_q;
endmodule

// File: rtl/store_miss_fill_chk.sv
module store_miss_fill_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_beat_valid,
  input logic              rd_beat_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              arr_we,
  input logic [1:0]        arr_state,
  input logic              mcheck
);
  localparam int CW = $clog2(LINE_WORDS + 1);
  logic [CW-1:0] beats_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               beats_seen <= '0;
    else if (rd_req_valid && rd_req_ready)    beats_seen <= '0;
    else if (rd_beat_valid && rd_beat_ready)  beats_seen <= beats_seen + 1'b1;
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));
  assert_four_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> beats_seen == CW'(LINE_WORDS));
  assert_fault_beats_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mcheck |-> beats_seen == CW'(LINE_WORDS) && !arr_we);
  assert_mc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mcheck |=> !mcheck);
  assert_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> arr_state == 2'b11);
  assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |=> !st_ready);
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we && st_ready);
endmodule

bind store_miss_fill store_miss_fill_chk #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)
) u_chk (.*);

// File: tb/tb_store_miss_fill.sv
`timescale 1ns/100ps
module tb_store_miss_fill;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 0, st_inhibit = 0;
  logic [31:0]  st_addr = 0, st_data = 0;
  logic [3:0]   st_be = 0;
  logic         st_ready, st_done;
  logic         rd_req_valid, rd_req_ready = 0;
  logic [31:0]  rd_req_addr;
  logic         rd_beat_valid = 0, rd_beat_ready, rd_beat_err = 0;
  logic [31:0]  rd_beat_data = 0;
  logic         wr_valid, wr_ready = 0;
  logic [31:0]  wr_addr, wr_data;
  logic [3:0]   wr_be;
  logic         arr_we, mcheck;
  logic [31:0]  arr_addr;
  logic [127:0] arr_data;
  logic [1:0]   arr_state;

  int checks = 0, failures = 0, cycles = 0;
  bit mon_on = 0, exp_wr_now = 0, exp_mc_now = 0;

  always #2.5 clk = ~clk;

  store_miss_fill dut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memw(input logic [31:0] a);
    return 32'hC3A5_0000 ^ (a * 32'h0001_0033) ^ {a[9:2], 24'h0};
  endfunction

  // Reference model checked every cycle: line writes and machine checks only when expected.
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      chk(arr_we == exp_wr_now, "R4 monitor arr_we", arr_we, exp_wr_now);
      chk(mcheck == exp_mc_now, "R6 monitor mcheck", mcheck, exp_mc_now);
      if (!st_ready) chk(!(rd_req_valid && wr_valid), "R7 monitor exclusive", {rd_req_valid, wr_valid}, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic fill_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                            input int err_beat, input int req_wait, input int gap);
    int crit;
    logic [127:0] exp_line;
    crit = int'(a[3:2]);
    for (int w = 0; w < 4; w++) begin
      logic [31:0] m;
      m = memw({a[31:4], 2'(w), 2'b00});
      if (w == crit)
        for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = d[b*8 +: 8];
      exp_line[w*32 +: 32] = m;
    end
    @(negedge clk);
    chk(st_ready == 1, "R5 idle ready", st_ready, 1);
    st_valid = 1; st_addr = a; st_data = d; st_be = be; st_inhibit = 0;
    @(negedge clk);
    st_valid = 0;
    chk(st_ready == 0, "R5 busy", st_ready, 0);
    chk(wr_valid == 0, "R1 no pass-through", wr_valid, 0);
    for (int i = 0; i < req_wait; i++) begin
      chk(rd_req_valid && rd_req_addr == {a[31:2], 2'b00}, "R8 req held", rd_req_addr, {a[31:2], 2'b00});
      @(negedge clk);
    end
    chk(rd_req_valid == 1, "R1 req valid", rd_req_valid, 1);
    chk(rd_req_addr == {a[31:2], 2'b00}, "R1 req addr", rd_req_addr, {a[31:2], 2'b00});
    rd_req_ready = 1;
    @(negedge clk);
    rd_req_ready = 0;
    chk(rd_req_valid == 0, "R1 single req", rd_req_valid, 0);
    for (int k = 0; k < 4; k++) begin
      for (int g = 0; g < gap; g++) begin
        chk(rd_beat_ready == 1, "R8 beat ready in fill", rd_beat_ready, 1);
        @(negedge clk);
      end
      rd_beat_valid = 1;
      rd_beat_data  = memw({a[31:4], 2'((crit + k) % 4), 2'b00});
      rd_beat_err   = (k == err_beat);
      chk(rd_beat_ready == 1, "R2 beat accepted", rd_beat_ready, 1);
      @(negedge clk);
      rd_beat_valid = 0; rd_beat_err = 0;
    end
    chk(rd_beat_ready == 0, "R8 beat ready drops", rd_beat_ready, 0);
    if (err_beat < 0) begin
      exp_wr_now = 1;
      chk(arr_we == 1, "R4 line write", arr_we, 1);
      chk(arr_addr == {a[31:4], 4'h0}, "R4 line addr", arr_addr, {a[31:4], 4'h0});
      chk(arr_state == 2'b11, "R4 modified-valid", arr_state, 2'b11);
      chk(st_done == 1, "R4 done", st_done, 1);
      for (int w = 0; w < 4; w++)
        chk(arr_data[w*32 +: 32] == exp_line[w*32 +: 32], (w == crit) ? "R3 merged word" : "R2 fill word",
            arr_data[w*32 +: 32], exp_line[w*32 +: 32]);
    end else begin
      exp_mc_now = 1;
      chk(mcheck == 1, "R6 machine check", mcheck, 1);
      chk(arr_we == 0, "R6 no write", arr_we, 0);
      chk(st_done == 0, "R6 no done", st_done, 0);
    end
    @(negedge clk);
    exp_wr_now = 0; exp_mc_now = 0;
    chk(st_ready == 1, "R5 ready after", st_ready, 1);
    chk(st_done == 0, "R4 done pulse", st_done, 0);
  endtask

  task automatic pass_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input int wait_c);
    @(negedge clk);
    chk(st_ready == 1, "R5 idle ready", st_ready, 1);
    st_valid = 1; st_addr = a; st_data = d; st_be = be; st_inhibit = 1;
    @(negedge clk);
    st_valid = 0; st_inhibit = 0; st_addr = 0; st_data = 0; st_be = 0;
    for (int i = 0; i <= wait_c; i++) begin
      chk(wr_valid == 1, "R7 write valid", wr_valid, 1);
      chk(wr_addr == a, "R7 write addr", wr_addr, a);
      chk(wr_data == d, "R7 write data", wr_data, d);
      chk(wr_be == be, "R7 write be", wr_be, be);
      chk(rd_req_valid == 0, "R7 no burst", rd_req_valid, 0);
      if (i < wait_c) begin
        chk(st_done == 0, "R7 done waits", st_done, 0);
        @(negedge clk);
      end
    end
    wr_ready = 1;
    #1;
    chk(st_done == 1, "R7 done on handshake", st_done, 1);
    @(negedge clk);
    wr_ready = 0;
    chk(wr_valid == 0, "R7 single write", wr_valid, 0);
    chk(st_ready == 1, "R5 ready after pass", st_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(st_ready == 1, "R9 reset ready", st_ready, 1);
    chk(rd_req_valid == 0 && rd_beat_ready == 0, "R9 reset bus idle", {rd_req_valid, rd_beat_ready}, 0);
    chk(wr_valid == 0 && arr_we == 0, "R9 reset no writes", {wr_valid, arr_we}, 0);
    chk(mcheck == 0 && st_done == 0, "R9 reset no pulses", {mcheck, st_done}, 0);
    rst_n = 1;
    mon_on = 1;
    fill_store(32'h0000_1000, 32'h1122_3344, 4'hF, -1, 0, 0);
    fill_store(32'h0000_2028, 32'hAABB_CCDD, 4'b0101, -1, 2, 1);
    fill_store(32'h0040_003F, 32'hDEAD_BEEF, 4'b1000, -1, 1, 0);
    fill_store(32'h0000_3014, 32'h5555_5555, 4'b0000, -1, 0, 2);
    fill_store(32'h0000_4044, 32'h0F0F_0F0F, 4'hF, 2, 0, 0);
    fill_store(32'h0000_5058, 32'h1234_5678, 4'b0110, 0, 1, 1);
    fill_store(32'h0000_6064, 32'h9999_AAAA, 4'b0011, -1, 0, 0);
    pass_store(32'h8000_0013, 32'hCAFE_F00D, 4'b1010, 2);
    pass_store(32'h8000_0100, 32'h0BAD_C0DE, 4'hF, 0);
    fill_store(32'h0000_700C, 32'h7777_8888, 4'b1100, 3, 0, 0);
    fill_store(32'h0000_8000, 32'h0102_0304, 4'b1001, -1, 0, 0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule